// File: doc/BRIEF.md
# Byte-Masked Memory Data Path

This block sits on the 32-bit data side of a synchronous DRAM-style memory. It holds a small word array. A write stores only the byte lanes that its mask leaves enabled. A read returns a word after a fixed two-clock latency, and the read's mask lanes decide which lanes carry data and which are shown as high-impedance.

The two directions treat the mask differently. A write mask acts in the cycle it arrives, so it gates the byte enables of the array directly. A read mask is delayed by two stages, so that it lines up with the word it governs. High-impedance is modelled as a low per-lane output enable, and the data in that lane is forced to zero.

Each read carries its own delayed mask. Reads issued back to back with different masks therefore each see their own lane pattern. Command sequencing and refresh are handled elsewhere.

Top module: `sdram_bytemask_path`

## Requirements
- R1: Mask bit i governs data bits 8*i+7 down to 8*i, for i = 0 to 3. Bit 0 is the lowest byte.
- R2: When `wr_req` is high, every byte whose `mask` bit is 0 takes the value of `wdata` in that lane. Every byte whose `mask` bit is 1 keeps its previous contents.
- R3: A write is visible to a read issued in the next cycle.
- R4: When `rd_req` is sampled high at a rising edge, `rd_valid` is high after the second rising edge that follows. At all other times it is low, unless another read causes it.
- R5: A read-mask bit of 1, sampled with the read command, drives the matching `lane_oe` bit low and the matching `rdata` byte to zero when the read's data appears.
- R6: A read-mask bit of 0 drives the matching `lane_oe` bit high, and the matching `rdata` byte carries the stored byte.
- R7: Reads issued on consecutive cycles each apply their own mask to their own data.
- R8: While `rd_valid` is low, `lane_oe` is 0000 and `rdata` is zero.
- R9: If `rd_req` and `wr_req` are high in the same cycle, the write is performed and the read is dropped: no `rd_valid` follows for it.
- R10: After a synchronous reset, the outputs are zero and every word of the array reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read strobe |
| wr_req | input | 1 | Write strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| mask | input | 4 | Per-byte mask; 1 suppresses the lane |
| rdata | output | 32 | Read data; masked lanes are zero |
| lane_oe | output | 4 | Per-lane output enable for read data |
| rd_valid | output | 1 | Read data present |

## Verification
The hardest case to reach is two reads in flight at once, one in each pipeline stage, carrying different masks. A mix-up between the two stages only shows when neighbouring reads differ in both address and mask. The stimulus therefore issues an unbroken run of reads over all addresses. Each read's mask is derived from its address, so every pair of neighbours differs. A read paired with a write in the same cycle is also placed between plain reads, so that the gap it leaves is visible.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    typedef logic [LANES-1:0]  lane_vec_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic      vld;
        lane_vec_t mask;
    } rd_tag_t;

    function automatic word_t lane_expand(input lane_vec_t en);
        word_t r;
        for (int i = 0; i < LANES; i++) begin
            r[i*LANE_W +: LANE_W] = {LANE_W{en[i]}};
        end
        return r;
    endfunction
endpackage

// File: rtl/bytemask_array.sv
module bytemask_array
    import sdm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  word_t             wdata,
    input  lane_vec_t         wmask,
    input  logic [ADDR_W-1:0] raddr,
    output word_t             rword
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int w = 0; w < DEPTH; w++) begin
                    store[w] <= '0;
                end
            end else if (we && !wmask[g]) begin
                store[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rword[g*LANE_W +: LANE_W] = store[raddr];
    end
endmodule

// File: rtl/rd_tag_pipe.sv
module rd_tag_pipe
    import sdm_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  rd_tag_t tag_in,
    output rd_tag_t tag_out
);
    rd_tag_t stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stg[s] <= '0;
            end else if (s == 0) begin
                stg[s] <= tag_in;
            end else begin
                stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign tag_out = stg[STAGES-1];
endmodule

// File: rtl/rd_word_pipe.sv
module rd_word_pipe
    import sdm_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t word_in,
    output word_t word_out
);
    word_t stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stg[s] <= '0;
            end else if (s == 0) begin
                stg[s] <= load ? word_in : '0;
            end else begin
                stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign word_out = stg[STAGES-1];
endmodule

// File: rtl/sdram_bytemask_path.sv
module sdram_bytemask_path
    import sdm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [3:0]        mask,
    output logic [31:0]       rdata,
    output logic [3:0]        lane_oe,
    output logic              rd_valid
);
    localparam int RD_LAT = 2;

    logic    rd_issue;
    word_t   arr_word;
    word_t   piped_word;
    rd_tag_t tag_in;
    rd_tag_t tag_out;

    assign rd_issue = rd_req && !wr_req;

    bytemask_array #(.ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_req),
        .waddr (addr),
        .wdata (wdata),
        .wmask (mask),
        .raddr (addr),
        .rword (arr_word)
    );

    assign tag_in = '{vld: rd_issue, mask: mask};

    rd_tag_pipe #(.STAGES(RD_LAT)) u_tag (
        .clk     (clk),
        .rst     (rst),
        .tag_in  (tag_in),
        .tag_out (tag_out)
    );

    rd_word_pipe #(.STAGES(RD_LAT)) u_word (
        .clk      (clk),
        .rst      (rst),
        .load     (rd_issue),
        .word_in  (arr_word),
        .word_out (piped_word)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_gate
        logic drive;
        assign drive = tag_out.vld && !tag_out.mask[g];
        assign lane_oe[g] = drive;
        assign rdata[g*LANE_W +: LANE_W] = drive ? piped_word[g*LANE_W +: LANE_W] : '0;
    end

    assign rd_valid = tag_out.vld;
endmodule

// File: rtl/sdram_bytemask_path_chk.sv
module sdram_bytemask_path_chk (
    input logic        clk,
    input logic        rst,
    input logic        rd_req,
    input logic        wr_req,
    input logic [3:0]  mask,
    input logic [31:0] rdata,
    input logic [3:0]  lane_oe,
    input logic        rd_valid
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R4 and R9: valid follows an accepted read by exactly two edges
    p_rd_latency_r4: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (rd_valid == $past(rd_req && !wr_req, 2)));

    // R5, R6 and R7: lane enables follow the mask of the read two edges back
    p_oe_from_mask_r5: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && rd_valid) |-> (lane_oe == ~$past(mask, 2)));

    // R8: no lane is enabled while nothing is being returned
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (lane_oe == 4'b0000 && rdata == 32'h0));

    // R5: a disabled lane always carries zero data
    p_masked_zero_r5: assert property (@(posedge clk) disable iff (rst)
        ((rdata & ~sdm_pkg::lane_expand(lane_oe)) == 32'h0));

    // R10: the cycle after reset, the outputs are idle
    p_reset_idle_r10: assert property (@(posedge clk)
        $past(rst) |-> (!rd_valid && lane_oe == 4'b0000));
endmodule

bind sdram_bytemask_path sdram_bytemask_path_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_req   (rd_req),
    .wr_req   (wr_req),
    .mask     (mask),
    .rdata    (rdata),
    .lane_oe  (lane_oe),
    .rd_valid (rd_valid)
);

// File: tb/sdram_bytemask_path_tb_top.sv
`timescale 1ns/1ps
module sdram_bytemask_path_tb_top;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          rd_req, wr_req;
    logic [AW-1:0] addr;
    logic [31:0]   wdata;
    logic [3:0]    mask;
    logic [31:0]   rdata;
    logic [3:0]    lane_oe;
    logic          rd_valid;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [31:0] model [DEPTH];

    // expectation slots: a = issued last step, b = issued two steps ago
    logic        ea_v, eb_v;
    logic [3:0]  ea_oe, eb_oe;
    logic [31:0] ea_d, eb_d;
    string       ea_tag, eb_tag;

    always #2 clk = ~clk;

    sdram_bytemask_path #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req),
        .addr(addr), .wdata(wdata), .mask(mask),
        .rdata(rdata), .lane_oe(lane_oe), .rd_valid(rd_valid)
    );

    function automatic logic [31:0] expand(input logic [3:0] en);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[i*8 +: 8] = {8{en[i]}};
        return r;
    endfunction

    task automatic check_out(input string tag, input logic v,
                             input logic [3:0] oe, input logic [31:0] d);
        checks++;
        if (rd_valid !== v || lane_oe !== oe || rdata !== d) begin
            failures++;
            $display("FAIL %s: got valid=%b oe=%b data=%h, expected valid=%b oe=%b data=%h",
                     tag, rd_valid, lane_oe, rdata, v, oe, d);
        end
    endtask

    // called just after a falling edge: check, then drive one command
    task automatic step(input logic rd, input logic wr, input logic [AW-1:0] a,
                        input logic [31:0] d, input logic [3:0] m, input string tag);
        logic [31:0] keep;
        check_out(eb_tag, eb_v, eb_oe, eb_d);
        eb_v = ea_v; eb_oe = ea_oe; eb_d = ea_d; eb_tag = ea_tag;
        if (wr) begin
            keep = expand(m);
            model[a] = (model[a] & keep) | (d & ~keep);
            ea_v = 1'b0; ea_oe = 4'b0; ea_d = '0;
            ea_tag = (rd) ? "R9" : "R8";
        end else if (rd) begin
            ea_v = 1'b1; ea_oe = ~m; ea_d = model[a] & expand(~m);
            ea_tag = tag;
        end else begin
            ea_v = 1'b0; ea_oe = 4'b0; ea_d = '0; ea_tag = "R8";
        end
        rd_req = rd; wr_req = wr; addr = a; wdata = d; mask = m;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, '0, '0, 4'h0, "R8");
    endtask

    initial begin
        #400000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog: got no finish, expected finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; rd_req = 0; wr_req = 0; addr = '0; wdata = '0; mask = '0;
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        ea_v = 0; eb_v = 0; ea_oe = 0; eb_oe = 0; ea_d = 0; eb_d = 0;
        ea_tag = "R8"; eb_tag = "R8";
        repeat (3) @(negedge clk);
        check_out("R10 reset outputs", 1'b0, 4'b0, 32'h0);
        rst = 1'b0;

        // R10: array is cleared
        for (int a = 0; a < DEPTH; a++) step(1, 0, a[AW-1:0], '0, 4'h0, "R10");
        idle(2);

        // R2: full writes with all lanes enabled
        for (int a = 0; a < DEPTH; a++)
            step(0, 1, a[AW-1:0], 32'hA5000000 ^ (a * 32'h01030507), 4'h0, "R2");

        // R1, R2, R3: every write mask, read back on the next cycle
        for (int m = 0; m < 16; m++) begin
            step(0, 1, m[AW-1:0], 32'h11223344 * (m + 1), m[3:0], "R1");
            step(1, 0, m[AW-1:0], '0, 4'h0, "R3");
        end
        idle(2);

        // R5, R6, R7: unbroken run of reads, every neighbour differs in mask
        for (int a = 0; a < DEPTH; a++)
            step(1, 0, a[AW-1:0], '0, a[3:0] ^ 4'h5, "R7");
        for (int m = 0; m < 16; m++)
            step(1, 0, 4'(m % DEPTH), '0, m[3:0], (m == 15) ? "R5" : "R6");

        // R9: read colliding with a write, placed between plain reads
        step(1, 0, 4'd3, '0, 4'h0, "R4");
        step(1, 1, 4'd3, 32'hDEADBEEF, 4'h6, "R9");
        step(1, 0, 4'd3, '0, 4'h0, "R9");
        idle(3);

        // R4: isolated reads at varying spacing
        for (int gap = 0; gap < 4; gap++) begin
            step(1, 0, 4'(gap + 7), '0, 4'h0, "R4");
            idle(gap);
        end
        idle(3);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule